// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked master that sits between a simple request/done command port and the pins of an asynchronous static RAM. The RAM has an active-low and an active-high chip select, two active-low byte-lane enables, an active-low write strobe, an active-low output enable and an active-low width-select pin. Each accepted command is turned into one complete pin-level read or write cycle. Every minimum interval is a counter whose limit is the ceiling of a nanosecond figure divided by the clock period `CLK_NS`.

Two widths are supported. In word mode the command's byte address drops its bit 0, and a 2-bit lane mask picks the bytes to write. In byte mode the width pin is held low, both lane enables are asserted, bit 0 of the byte address goes out on a separate low-address pin, and only the low eight data bits carry data. A change of width is slow: the selects must stay inactive for a long settle interval (5 ms by default) before and after the width pin moves. After a read, a short turnaround keeps the controller off the data bus while the RAM's output drivers turn off.

Top module: `sram_ctl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each taken request produces exactly one single-cycle `done` pulse, and `req_ready` is low during that pulse.
- R2: A word read holds `mem_oe_n` low, both selects active and both lane enables low for at least ceil(70 ns / CLK_NS) cycles, and never fewer than ceil(35 ns / CLK_NS). `rdata` carries the bus value sampled on the last of those cycles and is valid while `done` is high.
- R3: A word write drives lane enable bit i low exactly when lane-mask bit i is 1. Bit 0 is the lower byte (data bits 7:0) and bit 1 is the upper byte. Bytes that are not selected keep their contents.
- R4: During a write, `mem_we_n` stays low for at least ceil(max(55, 65, 35) ns / CLK_NS) cycles, and only while both selects are active. Address and write data do not change while `mem_we_n` is low.
- R5: After `mem_oe_n` rises, at least ceil(25 ns / CLK_NS) cycles pass before `mem_dq_oe` is raised. `mem_dq_oe` is never high while `mem_oe_n` is low.
- R6: A word write with lane mask 00 completes with a `done` pulse and does not pulse `mem_we_n`. Memory contents stay unchanged, which a later read shows.
- R7: A byte-mode access holds `mem_byte_n` low and both lane enables low. Byte address bit 0 goes out on `mem_alo`, and data uses bits 7:0. A byte read returns zero in `rdata[15:8]`.
- R8: Before `mem_byte_n` changes, the selects have been inactive for at least ceil(SETTLE_NS / CLK_NS) cycles. After it changes, they stay inactive for at least that many cycles.
- R9: Between cycles the RAM is in standby: `mem_cs1_n` high, `mem_cs2` low, `mem_we_n` and `mem_oe_n` high, and `mem_dq_oe` low.
- R10: After reset the controller is idle with `req_ready` high, `done` low, all R9 standby levels on the pins, and `mem_byte_n` high (word mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller idle, command can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | ADDR_W+1 | Byte address; bit 0 ignored for word access |
| req_wdata | input | DATA_W | Write data; bits 7:0 used for byte access |
| req_lane | input | DATA_W/8 | Word-write lane mask |
| done | output | 1 | Single-cycle completion pulse |
| rdata | output | DATA_W | Read result, valid with done |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_alo | output | 1 | Byte-mode low address bit |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_be_n | output | DATA_W/8 | Active-low byte-lane enables |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_byte_n | output | 1 | Active-low byte-width select |
| mem_dq_out | output | DATA_W | Data driven to the RAM |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data returned by the RAM |

## Verification
A wrong sequencer state or counter shows at the pins within one access. It appears as a strobe pulse that is too short, an address that moves while the strobe is low, a data drive that starts inside the turnaround window, or a width change with the selects active. The bench measures each of these intervals in cycles as the cycle happens. A wrong latched lane, width or address shows later, as a readback miscompare on the next read of that location. The bench runs that read immediately, so the error surfaces within a few accesses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PRE  = 3'd1,
    S_POST = 3'd2,
    S_TURN = 3'd3,
    S_RD   = 3'd4,
    S_WR   = 3'd5,
    S_WREC = 3'd6,
    S_DONE = 3'd7
  } seq_state_e;

  function automatic int unsigned cdiv(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES   = 2,
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned WP_CYC  = 7,
  parameter int unsigned TA_CYC  = 3,
  parameter int unsigned SET_CYC = 500000,
  parameter int unsigned CNT_W   = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_byte,
  input  logic [LANES-1:0] req_lane,
  output seq_state_e       state_q,
  output seq_state_e       state_nxt,
  output logic             take,
  output logic             cap,
  output logic             req_ready,
  output logic             lat_write,
  output logic             lat_byte,
  output logic             mode_q
);

  localparam int unsigned TA_W = $clog2(TA_CYC + 2);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [TA_W-1:0]  turn_q;
  logic             lat_noop;
  logic             sel_write, sel_byte, sel_noop;
  seq_state_e       launch_st;
  logic [CNT_W-1:0] launch_cnt;
  logic             mode_en;

  assign req_ready = (state_q == S_IDLE);
  assign take      = req_ready && req_valid;
  assign cap       = (state_q == S_RD) && (cnt_q == '0);
  assign mode_en   = (state_q == S_PRE) && (cnt_q == '0);

  // Fields used to pick the next cycle: live inputs in idle, latched ones later.
  always_comb begin
    if (state_q == S_IDLE) begin
      sel_write = req_write;
      sel_byte  = req_byte;
      sel_noop  = req_write && !req_byte && (req_lane == '0);
    end else begin
      sel_write = lat_write;
      sel_byte  = lat_byte;
      sel_noop  = lat_noop;
    end
  end

  always_comb begin
    launch_st  = S_RD;
    launch_cnt = CNT_W'(RD_CYC - 1);
    if (sel_write && sel_noop) begin
      launch_st  = S_DONE;
      launch_cnt = '0;
    end else if (sel_byte != mode_q) begin
      launch_st  = S_PRE;
      launch_cnt = CNT_W'(SET_CYC - 1);
    end else if (sel_write && (turn_q > TA_W'(1))) begin
      launch_st  = S_TURN;
      launch_cnt = '0;
    end else if (sel_write) begin
      launch_st  = S_WR;
      launch_cnt = CNT_W'(WP_CYC - 1);
    end
  end

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    case (state_q)
      S_IDLE: if (take) begin
        state_nxt = launch_st;
        cnt_nxt   = launch_cnt;
      end
      S_PRE: if (cnt_q == '0) begin
        state_nxt = S_POST;
        cnt_nxt   = CNT_W'(SET_CYC - 1);
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
      S_POST: if (cnt_q == '0) begin
        state_nxt = launch_st;
        cnt_nxt   = launch_cnt;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
      S_TURN: begin
        state_nxt = launch_st;
        cnt_nxt   = launch_cnt;
      end
      S_RD: if (cnt_q == '0) begin
        state_nxt = S_DONE;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
      S_WR: if (cnt_q == '0) begin
        state_nxt = S_WREC;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
      S_WREC: state_nxt = S_DONE;
      S_DONE: state_nxt = S_IDLE;
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write <= 1'b0;
      lat_byte  <= 1'b0;
      lat_noop  <= 1'b0;
    end else if (take) begin
      lat_write <= req_write;
      lat_byte  <= req_byte;
      lat_noop  <= req_write && !req_byte && (req_lane == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (mode_en) begin
      mode_q <= lat_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= '0;
    end else if (cap) begin
      turn_q <= TA_W'(TA_CYC);
    end else if (turn_q != '0) begin
      turn_q <= turn_q - 1'b1;
    end
  end

  // R1: a command is only taken from idle, so done never follows done
  assert_take_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (state_q != S_IDLE));

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned WP_CYC = 7,
  parameter int unsigned TA_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_nxt,
  input  logic              take,
  input  logic              cap,
  input  logic              mode_q,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_lane,
  input  logic              lat_write,
  input  logic              lat_byte,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_alo,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic [LANES-1:0]  mem_be_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out
);

  logic             cur_write, cur_byte;
  logic [LANES-1:0] lane_q, cur_lane;
  logic             sel_nxt;
  logic [LANES-1:0] be_nxt;

  assign cur_write = take ? req_write : lat_write;
  assign cur_byte  = take ? req_byte  : lat_byte;
  assign cur_lane  = take ? req_lane  : lane_q;
  assign sel_nxt   = (state_nxt == S_RD) || (state_nxt == S_WR) || (state_nxt == S_WREC);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      be_nxt[i] = !sel_nxt || (cur_write && !cur_byte && !cur_lane[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs1_n <= 1'b1;
      mem_cs2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_be_n  <= '1;
      done      <= 1'b0;
    end else begin
      mem_cs1_n <= !sel_nxt;
      mem_cs2   <= sel_nxt;
      mem_oe_n  <= (state_nxt != S_RD);
      mem_we_n  <= (state_nxt != S_WR);
      mem_dq_oe <= (state_nxt == S_WR) || (state_nxt == S_WREC);
      mem_be_n  <= be_nxt;
      done      <= (state_nxt == S_DONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_alo    <= 1'b0;
      mem_dq_out <= '0;
      lane_q     <= '0;
    end else if (take) begin
      mem_addr   <= req_addr[ADDR_W:1];
      mem_alo    <= req_byte && req_addr[0];
      mem_dq_out <= req_byte ? {{(DATA_W-8){1'b0}}, req_wdata[7:0]} : req_wdata;
      lane_q     <= req_lane;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap) begin
      rdata <= lat_byte ? {{(DATA_W-8){1'b0}}, mem_dq_in[7:0]} : mem_dq_in;
    end
  end

  // Interval counters for the timing properties.
  localparam int unsigned CHK_W = $clog2(umax(WP_CYC, TA_CYC) + 2);
  localparam logic [CHK_W-1:0] CHK_MAX = '1;
  logic [CHK_W-1:0] we_run_q, quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run_q <= '0;
      quiet_q  <= CHK_MAX;
    end else begin
      we_run_q <= mem_we_n ? '0 : ((we_run_q == CHK_MAX) ? we_run_q : we_run_q + 1'b1);
      quiet_q  <= !mem_oe_n ? '0 : ((quiet_q == CHK_MAX) ? quiet_q : quiet_q + 1'b1);
    end
  end

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run_q >= CHK_W'(WP_CYC)));

  assert_we_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (quiet_q >= CHK_W'(TA_CYC)));

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_width_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs1_n |-> $stable(mode_q));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RD_NS     = 70,
  parameter int unsigned OEACC_NS  = 35,
  parameter int unsigned WP_NS     = 55,
  parameter int unsigned AW_NS     = 65,
  parameter int unsigned DS_NS     = 35,
  parameter int unsigned OFF_NS    = 25,
  parameter int unsigned SETTLE_NS = 5000000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_byte,
  input  logic [ADDR_W:0]       req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_lane,
  output logic                  done,
  output logic [DATA_W-1:0]     rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_alo,
  output logic                  mem_cs1_n,
  output logic                  mem_cs2,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic                  mem_byte_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in
);

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned RD_CYC  = umax(cdiv(RD_NS, CLK_NS), cdiv(OEACC_NS, CLK_NS));
  localparam int unsigned WP_CYC  = umax(cdiv(WP_NS, CLK_NS),
                                         umax(cdiv(AW_NS, CLK_NS), cdiv(DS_NS, CLK_NS)));
  localparam int unsigned TA_CYC  = cdiv(OFF_NS, CLK_NS);
  localparam int unsigned SET_CYC = umax(cdiv(SETTLE_NS, CLK_NS), 1);
  localparam int unsigned CNT_W   = $clog2(umax(SET_CYC, umax(RD_CYC, WP_CYC)) + 1);

  seq_state_e state_q, state_nxt;
  logic       take, cap, lat_write, lat_byte, mode_q;

  sram_ctl_seq #(
    .LANES  (LANES),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC),
    .SET_CYC(SET_CYC),
    .CNT_W  (CNT_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_byte (req_byte),
    .req_lane (req_lane),
    .state_q  (state_q),
    .state_nxt(state_nxt),
    .take     (take),
    .cap      (cap),
    .req_ready(req_ready),
    .lat_write(lat_write),
    .lat_byte (lat_byte),
    .mode_q   (mode_q)
  );

  sram_ctl_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES),
    .WP_CYC(WP_CYC),
    .TA_CYC(TA_CYC)
  ) pins_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_nxt (state_nxt),
    .take      (take),
    .cap       (cap),
    .mode_q    (mode_q),
    .req_write (req_write),
    .req_byte  (req_byte),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_lane  (req_lane),
    .lat_write (lat_write),
    .lat_byte  (lat_byte),
    .mem_dq_in (mem_dq_in),
    .done      (done),
    .rdata     (rdata),
    .mem_addr  (mem_addr),
    .mem_alo   (mem_alo),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_be_n  (mem_be_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_out(mem_dq_out)
  );

  assign mem_byte_n = !mode_q;

  // R9: the data bus is only driven inside a selected cycle
  assert_standby_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs1_n |-> (!mem_dq_oe && mem_we_n && mem_oe_n));

endmodule

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;

  localparam int ADDR_W  = 19;
  localparam int DATA_W  = 16;
  // Expected minimum intervals at a 10 ns clock.
  localparam int RD_MIN  = 7;
  localparam int WP_MIN  = 7;
  localparam int TA_MIN  = 3;
  localparam int SET_MIN = 100;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write, req_byte;
  logic              req_ready;
  logic [ADDR_W:0]   req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [1:0]        req_lane;
  logic              done;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_alo, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_byte_n, mem_dq_oe;
  logic [1:0]        mem_be_n;
  logic [DATA_W-1:0] mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  sram_ctl #(.CLK_NS(10), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_NS(1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_lane(req_lane), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_alo(mem_alo), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_be_n(mem_be_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_byte_n(mem_byte_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // RAM model (pin behaviour) and an independent reference image.
  logic [15:0] model [256];
  logic [15:0] refm  [256];

  always @(posedge mem_we_n) begin
    if (!mem_cs1_n && mem_cs2) begin
      if (!mem_byte_n) begin
        if (mem_alo) model[mem_addr[7:0]][15:8] <= mem_dq_out[7:0];
        else         model[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      end else begin
        if (!mem_be_n[0]) model[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
        if (!mem_be_n[1]) model[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
      end
    end
  end

  always_comb begin
    if (mem_cs1_n || !mem_cs2 || mem_oe_n) mem_dq_in = 16'hDEAD;
    else if (!mem_byte_n)
      mem_dq_in = mem_alo ? {8'hEE, model[mem_addr[7:0]][15:8]}
                          : {8'hEE, model[mem_addr[7:0]][7:0]};
    else mem_dq_in = model[mem_addr[7:0]];
  end

  typedef struct {
    logic        rd;
    logic        byt;
    logic        noop;
    logic [1:0]  lane;
    logic [15:0] data;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: computes the expected result from the reference image and pushes it.
  task automatic issue(input logic wr, input logic byt, input int baddr,
                       input logic [15:0] wd, input logic [1:0] ln);
    item_t it;
    int w;
    w = (baddr >> 1) & 255;
    it.rd = !wr; it.byt = byt; it.lane = ln; it.data = 16'h0;
    it.noop = wr && !byt && (ln == 2'b00);
    if (!wr) begin
      if (byt) it.data = {8'h00, baddr[0] ? refm[w][15:8] : refm[w][7:0]};
      else     it.data = refm[w];
    end else if (byt) begin
      if (baddr[0]) refm[w][15:8] = wd[7:0];
      else          refm[w][7:0]  = wd[7:0];
    end else begin
      if (ln[0]) refm[w][7:0]  = wd[7:0];
      if (ln[1]) refm[w][15:8] = wd[15:8];
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_byte = byt;
    req_addr = (ADDR_W+1)'(baddr); req_wdata = wd; req_lane = ln;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pin intervals and scoreboard comparison, sampled at the falling edge.
  int oe_run = 0, we_run = 0, quiet = 1000, hi_run = 1000, post = 0, we_since = 0;
  logic prev_oe = 1'b1, prev_we = 1'b1, prev_dqoe = 1'b0, prev_byte = 1'b1, prev_done = 1'b0;
  logic armed = 1'b0, we_stable = 1'b1;
  logic [ADDR_W-1:0] we_addr;
  logic [15:0] we_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n) oe_run++;
      else if (!prev_oe) begin
        chk(oe_run >= RD_MIN, "R2 read strobe width", oe_run, RD_MIN);
        oe_run = 0;
      end
      if (!mem_we_n && prev_we) begin
        we_since++; we_addr = mem_addr; we_data = mem_dq_out; we_stable = 1'b1; we_run = 0;
        if (q.size() > 0)
          chk(mem_be_n == (q[0].byt ? 2'b00 : ~q[0].lane), "R3 lane enables", mem_be_n,
              q[0].byt ? 2'b00 : ~q[0].lane);
      end
      if (!mem_we_n) begin
        we_run++;
        if (mem_addr != we_addr || mem_dq_out != we_data) we_stable = 1'b0;
      end else if (!prev_we) begin
        chk(we_run >= WP_MIN && we_stable, "R4 write pulse", we_run, WP_MIN);
      end
      if (mem_dq_oe && !prev_dqoe) chk(quiet >= TA_MIN, "R5 turnaround", quiet, TA_MIN);
      if (mem_oe_n) quiet++; else quiet = 0;
      if (mem_byte_n != prev_byte) begin
        chk(hi_run >= SET_MIN, "R8 settle before width change", hi_run, SET_MIN);
        post = 1; armed = 1'b1;
      end else if (armed && !mem_cs1_n) begin
        chk(post >= SET_MIN, "R8 settle after width change", post, SET_MIN);
        armed = 1'b0;
      end else if (armed) post++;
      if (mem_cs1_n) hi_run++; else hi_run = 0;
      if (!mem_byte_n && !mem_cs1_n && mem_be_n != 2'b00)
        chk(1'b0, "R7 byte-mode lane enables", mem_be_n, 0);
      if (prev_done)
        chk(mem_cs1_n && !mem_cs2 && !mem_dq_oe && mem_we_n && mem_oe_n, "R9 standby pins",
            {mem_cs1_n, mem_cs2, mem_dq_oe, mem_we_n, mem_oe_n}, 5'b10011);
      if (done) begin
        chk(!prev_done && !req_ready, "R1 done pulse", {prev_done, req_ready}, 0);
        if (q.size() == 0) chk(1'b0, "R1 unexpected done", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          if (it.rd) chk(rdata == it.data, it.byt ? "R7 byte read data" : "R2 word read data",
                         rdata, it.data);
          if (it.noop) chk(we_since == 0, "R6 empty mask strobe count", we_since, 0);
        end
        we_since = 0;
      end
      prev_oe = mem_oe_n; prev_we = mem_we_n; prev_dqoe = mem_dq_oe;
      prev_byte = mem_byte_n; prev_done = done;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      refm[i]  = 16'(i * 16'h0101) ^ 16'h5A3C;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
    req_addr = '0; req_wdata = '0; req_lane = 2'b00;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(req_ready && !done, "R10 handshake at reset", {req_ready, done}, 2'b10);
    chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && mem_byte_n,
        "R10 pins at reset", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe, mem_byte_n},
        6'b101101);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_cs1_n && mem_byte_n, "R10 idle after release",
        {req_ready, mem_cs1_n, mem_byte_n}, 3'b111);

    issue(1, 0, 'h10*2, 16'h1234, 2'b11);   // R3 full word
    issue(0, 0, 'h10*2, 0, 0);              // R2
    issue(1, 0, 'h11*2, 16'hAAAA, 2'b01);   // R3 low lane only
    issue(0, 0, 'h11*2, 0, 0);
    issue(1, 0, 'h12*2, 16'hBBBB, 2'b10);   // R3 high lane only
    issue(0, 0, 'h12*2, 0, 0);
    issue(1, 0, 'h13*2, 16'hCCCC, 2'b00);   // R6 empty mask
    issue(0, 0, 'h13*2, 0, 0);
    issue(0, 0, 'h20*2, 0, 0);              // R5 read then write
    issue(1, 0, 'h21*2, 16'h0F0F, 2'b11);
    issue(0, 0, 'h21*2, 0, 0);
    issue(1, 1, 'h30*2,   16'h0011, 0);     // R8 switch, R7 byte writes
    issue(1, 1, 'h30*2+1, 16'h0022, 0);
    issue(0, 1, 'h30*2,   0, 0);            // R7 byte reads
    issue(0, 1, 'h30*2+1, 0, 0);
    issue(0, 1, 'h10*2+1, 0, 0);
    issue(1, 1, 'h31*2+1, 16'h0077, 0);     // R5 byte read then write
    issue(0, 0, 'h30*2, 0, 0);              // R8 switch back, word view of bytes
    issue(0, 0, 'h31*2, 0, 0);
    issue(1, 0, 'h40*2, 16'hFFFF, 2'b11);
    issue(0, 0, 'h40*2, 0, 0);

    while (q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule